// File: doc/BRIEF.md
# Tiled Matrix Multiply-Accumulate Controller

This block produces one m×n tile of an output matrix C = A·B. A finished output tile is the sum of K_STEPS partial products, each taken from one m×k tile of A and one k×n tile of B. The block first claims an empty output slot and clears it, because the slot can still hold an older result. It then consumes input tile pairs one at a time from two input queues. For each pair it walks a grid of r×s by s×t micro-blocks, doing one signed multiply-accumulate per cycle, and adds the products into the output slot. After the last pair it offers the finished tile to an output queue and holds it until the queue takes it.

The input tiles and the output slot sit in external buffers. The block reads and writes them through plain address and data ports, and each read returns its data one cycle after the address. Inputs are stored blocked: every r×s block of A, every s×t block of B and every r×t block of C is contiguous. Each output element is read once per step, accumulated over all k products of that step in a register, and written back once. The queues are driven by level-valid signals and one-cycle release pulses.

Top module: `mm_tile_accum`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_tile_valid`, `out_slot_take`, `a_tile_release`, `b_tile_release` and `c_wr_en` are low, provided `out_slot_free` is low.
- R2: `out_slot_take` is high for exactly the one cycle in which an empty slot is claimed. It is never high while `out_slot_free` is low or while a finished tile is waiting (`out_tile_valid` high).
- R3: In the M×N cycles right after a claim, the block writes zero to C addresses 0, 1, …, M×N−1 in ascending order, one per cycle, before any accumulation.
- R4: A step starts only when `a_tile_valid` and `b_tile_valid` are both high. At the end of each step, `a_tile_release` and `b_tile_release` pulse together for one cycle, in the same cycle as that step's last C write.
- R5: Between a claim and `out_tile_valid` rising there are exactly K_STEPS release pulses on each input queue.
- R6: Each stored C element equals the signed sum, over all K_STEPS tile pairs and all k inner indices, of A(i,x)·B(x,j), wrapped to ACC_W bits. Whatever the slot held before the claim has no effect on it.
- R7: The buffer addresses follow the blocked layouts. With KB=K/S and NB=N/T, A(i,x) is at ((i/R)·KB + x/S)·R·S + (i%R)·S + x%S. B(x,j) is at ((x/S)·NB + j/T)·S·T + (x%S)·T + j%T. C(i,j) is at ((i/R)·NB + j/T)·R·T + (i%R)·T + j%T. Within a block, successive inner-index reads of A go to consecutive addresses.
- R8: Once `out_tile_valid` is high, it stays high until a cycle with `out_tile_ready` high, and drops in the following cycle.
- R9: If both input queues are valid throughout, `out_tile_valid` is high exactly M×N + 1 + K_STEPS·(M×N×K + 2) clock edges after the claim cycle.
- R10: While an input queue is not valid after the clear pass, the block makes no C write and no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_slot_free | input | 1 | An empty output slot is available |
| out_slot_take | output | 1 | One-cycle pulse: the slot is claimed |
| out_tile_valid | output | 1 | A finished tile is offered to the output queue |
| out_tile_ready | input | 1 | The output queue accepts the offered tile |
| a_tile_valid | input | 1 | An A tile is present at the head of its queue |
| a_tile_release | output | 1 | One-cycle pulse: the head A tile is consumed |
| a_rd_addr | output | $clog2(TILE_M·TILE_K) | A buffer read address |
| a_rd_data | input | DATA_W | A element, one cycle after its address, signed |
| b_tile_valid | input | 1 | A B tile is present at the head of its queue |
| b_tile_release | output | 1 | One-cycle pulse: the head B tile is consumed |
| b_rd_addr | output | $clog2(TILE_K·TILE_N) | B buffer read address |
| b_rd_data | input | DATA_W | B element, one cycle after its address, signed |
| c_rd_addr | output | $clog2(TILE_M·TILE_N) | Output slot read address |
| c_rd_data | input | ACC_W | Output slot element, one cycle after its address |
| c_wr_en | output | 1 | Output slot write enable |
| c_wr_addr | output | $clog2(TILE_M·TILE_N) | Output slot write address |
| c_wr_data | output | ACC_W | Output slot write data |

## Verification
The assertions assume that the external buffers return read data exactly one cycle after the address, with a read and a write in the same cycle returning the old value. They also assume that an input tile is not changed while it is being read. The bench models all three buffers with that one-cycle read latency. It changes an input tile only on the edge where the block releases it, and it refills the output slot with garbage only while a finished tile is waiting, when the block makes no writes. Only the B queue is ever stalled, and only between steps, so the valid inputs never drop while a step is running.

// File: rtl/mm_tile_pkg.sv
// Package: shared sequencer state encoding and loop-nest indices for the
// tiled multiply-accumulate controller. Assumes nothing about widths.
package mm_tile_pkg;

    // Phases of one output tile.
    typedef enum logic [2:0] {
        SQ_WAIT_OUT = 3'd0,  // waiting for an empty output slot
        SQ_ZERO     = 3'd1,  // clearing the claimed slot
        SQ_WAIT_IN  = 3'd2,  // waiting for an A and a B tile
        SQ_RUN      = 3'd3,  // issuing one product per cycle
        SQ_DRAIN    = 3'd4,  // last write of a step, inputs released
        SQ_PUSH     = 3'd5   // finished tile offered to the output queue
    } seq_state_t;

    // Loop nest, innermost first.
    localparam int unsigned LOOP_DEPTH = 6;
    localparam int unsigned LV_KIN  = 0;  // inner index within an s-block
    localparam int unsigned LV_KBLK = 1;  // s-block index along k
    localparam int unsigned LV_JIN  = 2;  // column within a t-block
    localparam int unsigned LV_IIN  = 3;  // row within an r-block
    localparam int unsigned LV_JBLK = 4;  // t-block index along n
    localparam int unsigned LV_IBLK = 5;  // r-block index along m

endpackage

// File: rtl/mm_loop_gen.sv
// Module: mm_loop_gen
// Walks the six-deep micro-block loop nest and produces the blocked read
// addresses of A, B and C for every product issued.
// Assumes: every tile dimension is a multiple of its block dimension.
module mm_loop_gen
    import mm_tile_pkg::*;
#(
    parameter int unsigned TILE_M = 64,
    parameter int unsigned TILE_K = 64,
    parameter int unsigned TILE_N = 64,
    parameter int unsigned BLK_R  = 4,
    parameter int unsigned BLK_S  = 8,
    parameter int unsigned BLK_T  = 4,
    localparam int unsigned A_AW  = $clog2(TILE_M * TILE_K),
    localparam int unsigned B_AW  = $clog2(TILE_K * TILE_N),
    localparam int unsigned C_AW  = $clog2(TILE_M * TILE_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    output logic [A_AW-1:0] a_addr,
    output logic [B_AW-1:0] b_addr,
    output logic [C_AW-1:0] c_addr,
    output logic            elem_first,
    output logic            elem_last,
    output logic            pass_last
);

    localparam int unsigned KB = TILE_K / BLK_S;
    localparam int unsigned NB = TILE_N / BLK_T;
    localparam int unsigned MB = TILE_M / BLK_R;
    localparam int unsigned CW = $clog2(TILE_M + TILE_K + TILE_N + 1);

    // Trip count of each loop level.
    function automatic int unsigned lim_of(input int unsigned lvl);
        case (lvl)
            LV_KIN:  return BLK_S;
            LV_KBLK: return KB;
            LV_JIN:  return BLK_T;
            LV_IIN:  return BLK_R;
            LV_JBLK: return NB;
            default: return MB;
        endcase
    endfunction

    logic [CW-1:0]         cnt [LOOP_DEPTH];
    logic [LOOP_DEPTH-1:0] wrap;
    logic [LOOP_DEPTH:0]   carry;

    // Ripple the advance through the levels that are at their last value.
    always_comb begin
        carry[0] = advance;
        for (int unsigned i = 0; i < LOOP_DEPTH; i++) begin
            carry[i+1] = carry[i] & wrap[i];
        end
    end

    for (genvar g = 0; g < LOOP_DEPTH; g++) begin : g_lvl
        localparam int unsigned LIM = lim_of(g);
        assign wrap[g] = (cnt[g] == CW'(LIM - 1));

        // One loop counter: cleared between steps, stepped by its carry.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                cnt[g] <= '0;
            end else if (carry[g]) begin
                cnt[g] <= wrap[g] ? '0 : cnt[g] + 1'b1;
            end
        end
    end

    // Blocked addresses from the current loop indices.
    always_comb begin
        a_addr = A_AW'((int'(cnt[LV_IBLK]) * KB + int'(cnt[LV_KBLK])) * BLK_R * BLK_S
                     + int'(cnt[LV_IIN]) * BLK_S + int'(cnt[LV_KIN]));
        b_addr = B_AW'((int'(cnt[LV_KBLK]) * NB + int'(cnt[LV_JBLK])) * BLK_S * BLK_T
                     + int'(cnt[LV_KIN]) * BLK_T + int'(cnt[LV_JIN]));
        c_addr = C_AW'((int'(cnt[LV_IBLK]) * NB + int'(cnt[LV_JBLK])) * BLK_R * BLK_T
                     + int'(cnt[LV_IIN]) * BLK_T + int'(cnt[LV_JIN]));
    end

    // Element boundaries and end of the whole pass.
    assign elem_first = (cnt[LV_KIN] == '0) && (cnt[LV_KBLK] == '0);
    assign elem_last  = wrap[LV_KIN] && wrap[LV_KBLK];
    assign pass_last  = &wrap;

    AST_A_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && !wrap[LV_KIN]) |=> (a_addr == A_AW'($past(a_addr) + 1'b1))) // R7
        else $error("A address not sequential within block");

endmodule

// File: rtl/mm_mac_stage.sv
// Module: mm_mac_stage
// Second pipeline stage: combines the read data of A, B and C into a
// running element sum and writes the sum back on the element's last product.
// Assumes: buffer read data arrives one cycle after the issued address.
module mm_mac_stage #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned C_AW   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_first,
    input  logic              issue_last,
    input  logic [C_AW-1:0]   issue_caddr,
    input  logic [DATA_W-1:0] a_rd_data,
    input  logic [DATA_W-1:0] b_rd_data,
    input  logic [ACC_W-1:0]  c_rd_data,
    output logic              wr_en,
    output logic [C_AW-1:0]   wr_addr,
    output logic [ACC_W-1:0]  wr_data
);

    logic                      p_valid, p_first, p_last;
    logic [C_AW-1:0]           p_caddr;
    logic signed [ACC_W-1:0]   acc;
    logic signed [2*DATA_W-1:0] prod;
    logic signed [ACC_W-1:0]   prod_ext;
    logic signed [ACC_W-1:0]   sum;

    // Capture the issue stage flags alongside the pending read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_first <= 1'b0;
            p_last  <= 1'b0;
            p_caddr <= '0;
        end else begin
            p_valid <= issue_valid;
            p_first <= issue_first;
            p_last  <= issue_last;
            p_caddr <= issue_caddr;
        end
    end

    // Signed product, extended to accumulator width, added to the element sum.
    always_comb begin
        prod     = $signed(a_rd_data) * $signed(b_rd_data);
        prod_ext = ACC_W'(prod);
        sum      = (p_first ? $signed(c_rd_data) : acc) + prod_ext;
    end

    // Running element sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (p_valid) begin
            acc <= sum;
        end
    end

    assign wr_en   = p_valid && p_last;
    assign wr_addr = p_caddr;
    assign wr_data = sum;

    // Checker state: an element has been opened and not yet written back.
    logic open_elem;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_elem <= 1'b0;
        end else if (issue_valid && issue_first) begin
            open_elem <= 1'b1;
        end else if (wr_en) begin
            open_elem <= 1'b0;
        end
    end

    AST_ELEM_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_first) |-> (!open_elem || wr_en)) // R6
        else $error("new element opened before the previous one was written");

endmodule

// File: rtl/mm_tile_seq.sv
// Module: mm_tile_seq
// Phase sequencer: claims an output slot, clears it, runs K_STEPS passes
// over input tile pairs, releases each pair, and offers the finished tile.
// Assumes: the loop generator raises pass_last on the final issue of a pass.
module mm_tile_seq
    import mm_tile_pkg::*;
#(
    parameter int unsigned K_STEPS  = 8,
    parameter int unsigned ZERO_CNT = 4096,
    parameter int unsigned C_AW     = 12,
    localparam int unsigned SW      = $clog2(K_STEPS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            out_slot_free,
    input  logic            out_tile_ready,
    input  logic            a_tile_valid,
    input  logic            b_tile_valid,
    input  logic            pass_last,
    output logic            slot_take,
    output logic            zero_we,
    output logic [C_AW-1:0] zero_addr,
    output logic            loop_clear,
    output logic            loop_adv,
    output logic            in_release,
    output logic            out_tile_valid
);

    seq_state_t      state;
    logic [C_AW-1:0] zcnt;
    logic [SW-1:0]   step;

    // Phase transitions, clear counter and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_WAIT_OUT;
            zcnt  <= '0;
            step  <= '0;
        end else begin
            case (state)
                SQ_WAIT_OUT: if (out_slot_free) begin
                    state <= SQ_ZERO;
                    zcnt  <= '0;
                    step  <= '0;
                end
                SQ_ZERO: begin
                    zcnt <= zcnt + 1'b1;
                    if (zcnt == C_AW'(ZERO_CNT - 1)) state <= SQ_WAIT_IN;
                end
                SQ_WAIT_IN: if (a_tile_valid && b_tile_valid) state <= SQ_RUN;
                SQ_RUN: if (pass_last) state <= SQ_DRAIN;
                SQ_DRAIN: begin
                    if (step == SW'(K_STEPS - 1)) begin
                        state <= SQ_PUSH;
                        step  <= '0;
                    end else begin
                        state <= SQ_WAIT_IN;
                        step  <= step + 1'b1;
                    end
                end
                SQ_PUSH: if (out_tile_ready) state <= SQ_WAIT_OUT;
                default: state <= SQ_WAIT_OUT;
            endcase
        end
    end

    // Phase-decoded controls.
    assign slot_take      = (state == SQ_WAIT_OUT) && out_slot_free;
    assign zero_we        = (state == SQ_ZERO);
    assign zero_addr      = zcnt;
    assign loop_clear     = (state == SQ_WAIT_IN);
    assign loop_adv       = (state == SQ_RUN);
    assign in_release     = (state == SQ_DRAIN);
    assign out_tile_valid = (state == SQ_PUSH);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tile_valid && !out_tile_ready) |=> out_tile_valid) // R8
        else $error("finished tile withdrawn before acceptance");

    AST_OUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tile_valid && out_tile_ready) |=> !out_tile_valid) // R8
        else $error("finished tile still offered after acceptance");

endmodule

// File: rtl/mm_tile_accum.sv
// Module: mm_tile_accum (top)
// Computes one output tile as the sum of K_STEPS tile-pair products, walking
// BLK_R x BLK_S by BLK_S x BLK_T micro-blocks, one MAC per cycle.
// Assumes: external buffers with one-cycle read latency; blocked layouts.
module mm_tile_accum
    import mm_tile_pkg::*;
#(
    parameter int unsigned TILE_M  = 64,
    parameter int unsigned TILE_K  = 64,
    parameter int unsigned TILE_N  = 64,
    parameter int unsigned BLK_R   = 4,
    parameter int unsigned BLK_S   = 8,
    parameter int unsigned BLK_T   = 4,
    parameter int unsigned K_STEPS = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ACC_W   = 32,
    localparam int unsigned A_AW   = $clog2(TILE_M * TILE_K),
    localparam int unsigned B_AW   = $clog2(TILE_K * TILE_N),
    localparam int unsigned C_AW   = $clog2(TILE_M * TILE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_slot_free,
    output logic              out_slot_take,
    output logic              out_tile_valid,
    input  logic              out_tile_ready,
    input  logic              a_tile_valid,
    output logic              a_tile_release,
    output logic [A_AW-1:0]   a_rd_addr,
    input  logic [DATA_W-1:0] a_rd_data,
    input  logic              b_tile_valid,
    output logic              b_tile_release,
    output logic [B_AW-1:0]   b_rd_addr,
    input  logic [DATA_W-1:0] b_rd_data,
    output logic [C_AW-1:0]   c_rd_addr,
    input  logic [ACC_W-1:0]  c_rd_data,
    output logic              c_wr_en,
    output logic [C_AW-1:0]   c_wr_addr,
    output logic [ACC_W-1:0]  c_wr_data
);

    localparam int unsigned ZERO_CNT = TILE_M * TILE_N;
    localparam int unsigned SW       = $clog2(K_STEPS + 1);

    logic            loop_clear, loop_adv, elem_first, elem_last, pass_last;
    logic            zero_we, in_release, mac_we;
    logic [C_AW-1:0] zero_addr, mac_addr, gen_caddr;
    logic [ACC_W-1:0] mac_data;

    mm_tile_seq #(
        .K_STEPS (K_STEPS),
        .ZERO_CNT(ZERO_CNT),
        .C_AW    (C_AW)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .out_slot_free (out_slot_free),
        .out_tile_ready(out_tile_ready),
        .a_tile_valid  (a_tile_valid),
        .b_tile_valid  (b_tile_valid),
        .pass_last     (pass_last),
        .slot_take     (out_slot_take),
        .zero_we       (zero_we),
        .zero_addr     (zero_addr),
        .loop_clear    (loop_clear),
        .loop_adv      (loop_adv),
        .in_release    (in_release),
        .out_tile_valid(out_tile_valid)
    );

    mm_loop_gen #(
        .TILE_M(TILE_M), .TILE_K(TILE_K), .TILE_N(TILE_N),
        .BLK_R (BLK_R),  .BLK_S (BLK_S),  .BLK_T (BLK_T)
    ) i_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (loop_clear),
        .advance   (loop_adv),
        .a_addr    (a_rd_addr),
        .b_addr    (b_rd_addr),
        .c_addr    (gen_caddr),
        .elem_first(elem_first),
        .elem_last (elem_last),
        .pass_last (pass_last)
    );

    mm_mac_stage #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W),
        .C_AW  (C_AW)
    ) i_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(loop_adv),
        .issue_first(elem_first),
        .issue_last (elem_last),
        .issue_caddr(gen_caddr),
        .a_rd_data  (a_rd_data),
        .b_rd_data  (b_rd_data),
        .c_rd_data  (c_rd_data),
        .wr_en      (mac_we),
        .wr_addr    (mac_addr),
        .wr_data    (mac_data)
    );

    // Output slot write port: clear pass or accumulate write-back.
    assign c_rd_addr      = gen_caddr;
    assign c_wr_en        = zero_we || mac_we;
    assign c_wr_addr      = zero_we ? zero_addr : mac_addr;
    assign c_wr_data      = zero_we ? '0 : mac_data;
    assign a_tile_release = in_release;
    assign b_tile_release = in_release;

    // Checker state: releases seen since the last slot claim.
    logic [SW-1:0] rel_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || out_slot_take) begin
            rel_cnt <= '0;
        end else if (in_release) begin
            rel_cnt <= rel_cnt + 1'b1;
        end
    end

    AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_slot_take && rst_n) |-> (c_wr_en && c_wr_addr == '0 && c_wr_data == '0)) // R3
        else $error("clear pass did not start at address zero");

    AST_REL_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        in_release |-> mac_we) // R4
        else $error("inputs released without the final write of the step");

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_tile_valid) |-> (rel_cnt == SW'(K_STEPS))) // R5
        else $error("finished tile offered after a wrong number of steps");

endmodule

// File: tb/test_mm_tile_accum.sv
// Bench: small configuration (4x4x4 tiles, 2x2x2 blocks, two steps), three
// output tiles with distinct value patterns; expected results computed here.
module test_mm_tile_accum;

    localparam int CLK_PERIOD = 10;
    localparam int TM = 4, TK = 4, TN = 4, BR = 2, BS = 2, BT = 2, KS = 2;
    localparam int DW = 8, AW = 16;
    localparam int NOUT = 3;
    localparam int NT = NOUT * KS;
    localparam int MN = TM * TN;
    localparam int MNK = TM * TN * TK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic out_slot_free = 1'b0, out_tile_ready = 1'b0;
    logic out_slot_take, out_tile_valid;
    logic a_tile_valid, a_tile_release, b_tile_valid, b_tile_release;
    logic [3:0] a_rd_addr, b_rd_addr, c_rd_addr, c_wr_addr;
    logic [DW-1:0] a_rd_data, b_rd_data;
    logic [AW-1:0] c_rd_data, c_wr_data;
    logic c_wr_en;

    int tests = 0, fails = 0;
    bit hold_b = 1'b0, scrub = 1'b0, finished = 1'b0;
    int a_head = 0, b_head = 0;
    int aval [NT][TM][TK];
    int bval [NT][TK][TN];
    logic [DW-1:0] amem [NT][TM*TK];
    logic [DW-1:0] bmem [NT][TK*TN];
    logic [AW-1:0] cmem [MN];

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_tile_accum #(
        .TILE_M(TM), .TILE_K(TK), .TILE_N(TN),
        .BLK_R(BR), .BLK_S(BS), .BLK_T(BT),
        .K_STEPS(KS), .DATA_W(DW), .ACC_W(AW)
    ) i_mm_tile_accum (
        .clk(clk), .rst_n(rst_n),
        .out_slot_free(out_slot_free), .out_slot_take(out_slot_take),
        .out_tile_valid(out_tile_valid), .out_tile_ready(out_tile_ready),
        .a_tile_valid(a_tile_valid), .a_tile_release(a_tile_release),
        .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
        .b_tile_valid(b_tile_valid), .b_tile_release(b_tile_release),
        .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
        .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data),
        .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data)
    );

    // Blocked address maps taken from R7.
    function automatic int a_map(int i, int x);
        return ((i/BR)*(TK/BS) + x/BS)*BR*BS + (i%BR)*BS + x%BS;
    endfunction
    function automatic int b_map(int x, int j);
        return ((x/BS)*(TN/BT) + j/BT)*BS*BT + (x%BS)*BT + j%BT;
    endfunction
    function automatic int c_map(int i, int j);
        return ((i/BR)*(TN/BT) + j/BT)*BR*BT + (i%BR)*BT + j%BT;
    endfunction

    assign a_tile_valid = (a_head < NT);
    assign b_tile_valid = (b_head < NT) && !hold_b;

    // Queue heads, buffer models with one-cycle read latency, slot scrubbing.
    always @(posedge clk) begin
        a_rd_data <= (a_head < NT) ? amem[a_head][a_rd_addr] : '0;
        b_rd_data <= (b_head < NT) ? bmem[b_head][b_rd_addr] : '0;
        c_rd_data <= cmem[c_rd_addr];
        if (scrub) begin
            for (int q = 0; q < MN; q++) cmem[q] <= AW'(16'h5A3C + q * 97);
        end else if (c_wr_en) begin
            cmem[c_wr_addr] <= c_wr_data;
        end
        if (a_tile_release) a_head <= a_head + 1;
        if (b_tile_release) b_head <= b_head + 1;
    end

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // Runs one output tile; optionally stalls the B queue after the clear pass.
    task automatic run_tile(input int t, input bit stall);
        int n = 0;
        int bad = 0;
        @(negedge clk);
        hold_b = stall;
        out_slot_free = 1'b1;
        #1;
        chk(out_slot_take === 1'b1, "R2 claim pulse", int'(out_slot_take), 1);
        while (!out_tile_valid) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                out_slot_free = 1'b0;
                chk(c_wr_en && c_wr_addr == 0 && c_wr_data == 0, "R3 clear start",
                    int'(c_wr_addr), 0);
                chk(out_slot_take === 1'b0, "R2 single pulse", int'(out_slot_take), 0);
            end
            if (stall && n > 1 && n <= MN + 20) begin
                if (a_tile_release || b_tile_release || (n > MN && c_wr_en)) bad++;
                if (n == MN + 20) begin
                    chk(bad == 0, "R10 stall quiet", bad, 0);
                    chk(a_head == t * KS, "R10 no release", a_head, t * KS);
                    hold_b = 1'b0;
                end
            end
            if (n > 100000) break;
        end
        if (!stall)
            chk(n == MN + 1 + KS * (MNK + 2), "R9 latency", n, MN + 1 + KS * (MNK + 2));
        chk(a_head == (t + 1) * KS, "R5 A releases", a_head, (t + 1) * KS);
        chk(b_head == (t + 1) * KS, "R5 B releases", b_head, (t + 1) * KS);
        // Pending tile: held, no new claim even with a free slot.
        out_slot_free = 1'b1;
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            chk(out_tile_valid === 1'b1, "R8 hold", int'(out_tile_valid), 1);
            chk(out_slot_take === 1'b0, "R2 no claim while pending", int'(out_slot_take), 0);
        end
        out_slot_free = 1'b0;
        // Result values, R6 and R7 layout of C.
        for (int i = 0; i < TM; i++) begin
            for (int j = 0; j < TN; j++) begin
                int sum = 0;
                for (int s = 0; s < KS; s++)
                    for (int x = 0; x < TK; x++)
                        sum += aval[t*KS+s][i][x] * bval[t*KS+s][x][j];
                chk(cmem[c_map(i, j)] == AW'(sum), "R6 element",
                    int'(cmem[c_map(i, j)]), int'(AW'(sum)));
            end
        end
        scrub = 1'b1;
        out_tile_ready = 1'b1;
        @(negedge clk);
        scrub = 1'b0;
        out_tile_ready = 1'b0;
        chk(out_tile_valid === 1'b0, "R8 drop", int'(out_tile_valid), 0);
    endtask

    initial begin
        // Input tile patterns: small mixed, extremes, random.
        for (int tt = 0; tt < NT; tt++) begin
            int grp = tt / KS;
            for (int i = 0; i < TM; i++)
                for (int x = 0; x < TK; x++) begin
                    if (grp == 0) aval[tt][i][x] = i - x + tt;
                    else if (grp == 1) aval[tt][i][x] = ((i + x + tt) % 2) ? 127 : -128;
                    else aval[tt][i][x] = int'($urandom_range(255)) - 128;
                    amem[tt][a_map(i, x)] = DW'(aval[tt][i][x]);
                end
            for (int x = 0; x < TK; x++)
                for (int j = 0; j < TN; j++) begin
                    if (grp == 0) bval[tt][x][j] = x + j - 3;
                    else if (grp == 1) bval[tt][x][j] = -128 + j;
                    else bval[tt][x][j] = int'($urandom_range(255)) - 128;
                    bmem[tt][b_map(x, j)] = DW'(bval[tt][x][j]);
                end
        end
        scrub = 1'b1;
        repeat (4) @(negedge clk);
        scrub = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_tile_valid === 1'b0, "R1 valid idle", int'(out_tile_valid), 0);
        chk(out_slot_take === 1'b0, "R1 no claim", int'(out_slot_take), 0);
        chk(c_wr_en === 1'b0, "R1 no write", int'(c_wr_en), 0);
        chk(a_tile_release === 1'b0 && b_tile_release === 1'b0, "R1 no release",
            int'(a_tile_release), 0);
        run_tile(0, 1'b0);
        run_tile(1, 1'b1);
        run_tile(2, 1'b0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog got=timeout exp=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule